// File: doc/BRIEF.md
# Two-Pattern Scan Chain with Hold Latches

This block is a scan chain for applying an arbitrary pair of state vectors to a piece of combinational logic for delay testing. Each chain position has a scan flip-flop and a hold latch. The latch sits between the flip-flop and the logic under test. While the latches hold, the logic keeps seeing the first vector (V1). Meanwhile the flip-flops are reloaded with the second vector (V2). V2 is therefore an independent value and is not derived from V1 by a shift or by a functional clock.

A built-in sequencer runs one test per start pulse. It first shifts V1 in and lets it reach the logic for a settle interval. Next it freezes the latches and shifts V2 in behind them. It then releases V2 to the logic together with the second primary-input value. After exactly a rated number of base-clock cycles it takes a single capture of the logic's response in normal mode. Finally it shifts the response out serially and collects it into a parallel word, then raises a done flag. The logic under test sits outside the block: it reads the latch outputs and the applied primary inputs, and it returns its response to the flip-flops.

Top module: `twopat_scan`

## Requirements
- R1: After reset, done_o is 0, hold_o is 0, scan_mode_o is 1, and cut_state_o and cut_pi_o are all zeros.
- R2: Shifting loads the chain from the scan input so that after a load, chain position i holds bit i of the vector given on v1_state_i or v2_state_i. The MSB of each vector is shifted in first.
- R3: While hold_o is 1, cut_state_o and cut_pi_o do not change. Through the whole V2 load, the logic sees V1 and the V1 primary-input value.
- R4: After the last V1 shift cycle, hold_o stays 0 for SETTLE_CYC cycles and then rises for the V2 load. cut_state_o equals V1 before hold_o rises.
- R5: One cycle after the V2 load ends, cut_state_o becomes V2 and cut_pi_o becomes the V2 primary-input value, both on the same edge. hold_o is 0 during that release cycle and during capture.
- R6: Capture happens on the edge exactly RATED_CYC cycles after the release edge. scan_mode_o is 0 only in that single capture cycle.
- R7: The captured word is the logic's response to V2. It appears on scan_out_o MSB first, one bit per cycle. resp_o holds the whole word once done_o rises.
- R8: done_o rises on the edge after the last shift-out and stays 1 until the next start is accepted.
- R9: start_i is ignored while a test is running.
- R10: Vectors and primary-input values are sampled when start is accepted. Later changes on those inputs do not affect the running test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast base clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start one two-pattern test |
| v1_state_i | input | CHAIN_LEN | First state vector |
| v2_state_i | input | CHAIN_LEN | Second state vector |
| v1_pi_i | input | PI_W | Primary-input value applied with V1 |
| v2_pi_i | input | PI_W | Primary-input value applied with V2 |
| cut_state_o | output | CHAIN_LEN | Hold-latch outputs driving the logic under test |
| cut_pi_o | output | PI_W | Primary inputs driving the logic under test |
| cut_resp_i | input | CHAIN_LEN | Response of the logic under test |
| scan_mode_o | output | 1 | 1 = scan/hold mode, 0 = normal capture cycle |
| hold_o | output | 1 | Common hold control of all latches |
| scan_out_o | output | 1 | Serial scan output (last chain position) |
| resp_o | output | CHAIN_LEN | Collected response word |
| done_o | output | 1 | Test finished; resp_o valid |

## Verification
The bench builds the block with CHAIN_LEN=4, PI_W=2, SETTLE_CYC=3 and RATED_CYC=2. With these values every one of the 256 (V1, V2) state pairs can be run, and the primary-input values are varied with the pair. Every cycle of each run is short enough to check against the expected phase timing: the settle window, the frozen V1, the release edge, the single capture cycle and the serial unload order. In half of the runs a stray start and corrupted input vectors are injected mid-test, so each pair also exercises the ignore and sampling rules.

// File: rtl/tps_pkg.sv
package tps_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOAD1,
    PH_SETTLE,
    PH_LOAD2,
    PH_LAUNCH,
    PH_RATED,
    PH_UNLOAD,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/tps_cell.sv
module tps_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic shift_i,
  input  logic capture_i,
  input  logic hold_i,
  input  logic scan_d_i,
  input  logic func_d_i,
  output logic ff_q_o,
  output logic lat_q_o
);
  logic ff_q, lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ff_q <= 1'b0;
    else if (shift_i)   ff_q <= scan_d_i;
    else if (capture_i) ff_q <= func_d_i;
  end

  // hold latch modelled as a register enabled while hold is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lat_q <= 1'b0;
    else if (!hold_i) lat_q <= ff_q;
  end

  assign ff_q_o  = ff_q;
  assign lat_q_o = lat_q;
endmodule

// File: rtl/tps_chain.sv
module tps_chain #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 shift_i,
  input  logic                 capture_i,
  input  logic                 hold_i,
  input  logic                 scan_in_i,
  input  logic [CHAIN_LEN-1:0] resp_i,
  output logic [CHAIN_LEN-1:0] state_o,
  output logic                 scan_out_o
);
  logic [CHAIN_LEN-1:0] ff_q;
  logic [CHAIN_LEN-1:0] scan_d;

  for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign scan_d[i] = scan_in_i;
    end else begin : g_body
      assign scan_d[i] = ff_q[i-1];
    end
    tps_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .shift_i   (shift_i),
      .capture_i (capture_i),
      .hold_i    (hold_i),
      .scan_d_i  (scan_d[i]),
      .func_d_i  (resp_i[i]),
      .ff_q_o    (ff_q[i]),
      .lat_q_o   (state_o[i])
    );
  end

  assign scan_out_o = ff_q[CHAIN_LEN-1];
endmodule

// File: rtl/tps_seq.sv
module tps_seq
  import tps_pkg::*;
#(
  parameter int CHAIN_LEN  = 8,
  parameter int PI_W       = 4,
  parameter int SETTLE_CYC = 4,
  parameter int RATED_CYC  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CHAIN_LEN-1:0] v1_state_i,
  input  logic [CHAIN_LEN-1:0] v2_state_i,
  input  logic [PI_W-1:0]      v1_pi_i,
  input  logic [PI_W-1:0]      v2_pi_i,
  output logic                 shift_o,
  output logic                 capture_o,
  output logic                 hold_o,
  output logic                 scan_in_o,
  output logic                 collect_o,
  output logic [PI_W-1:0]      pi_o,
  output logic                 done_o
);
  localparam int MAX_LEN = (CHAIN_LEN > SETTLE_CYC) ?
                           ((CHAIN_LEN > RATED_CYC) ? CHAIN_LEN : RATED_CYC) :
                           ((SETTLE_CYC > RATED_CYC) ? SETTLE_CYC : RATED_CYC);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] N_LAST = CW'(CHAIN_LEN - 1);
  localparam logic [CW-1:0] S_LAST = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] R_LAST = CW'(RATED_CYC - 1);

  phase_e ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CHAIN_LEN-1:0] v1_q, v2_q, vsel, vsh;
  logic [PI_W-1:0] pi1_q, pi2_q, pi_q;
  logic accept;

  assign accept = start_i && (ph_q == PH_IDLE || ph_q == PH_DONE);

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q + 1'b1;
    unique case (ph_q)
      PH_IDLE, PH_DONE: begin
        cnt_d = '0;
        if (start_i) ph_d = PH_LOAD1;
      end
      PH_LOAD1:  if (cnt_q == N_LAST) begin ph_d = PH_SETTLE; cnt_d = '0; end
      PH_SETTLE: if (cnt_q == S_LAST) begin ph_d = PH_LOAD2;  cnt_d = '0; end
      PH_LOAD2:  if (cnt_q == N_LAST) begin ph_d = PH_LAUNCH; cnt_d = '0; end
      PH_LAUNCH: begin ph_d = PH_RATED; cnt_d = '0; end
      PH_RATED:  if (cnt_q == R_LAST) begin ph_d = PH_UNLOAD; cnt_d = '0; end
      PH_UNLOAD: if (cnt_q == N_LAST) begin ph_d = PH_DONE;   cnt_d = '0; end
      default:   begin ph_d = PH_IDLE; cnt_d = '0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q  <= '0;
      v2_q  <= '0;
      pi1_q <= '0;
      pi2_q <= '0;
    end else if (accept) begin
      v1_q  <= v1_state_i;
      v2_q  <= v2_state_i;
      pi1_q <= v1_pi_i;
      pi2_q <= v2_pi_i;
    end
  end

  // primary inputs: V1 value from start, V2 value on the release edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pi_q <= '0;
    else if (accept)            pi_q <= v1_pi_i;
    else if (ph_q == PH_LAUNCH) pi_q <= pi2_q;
  end

  // MSB first: bit at count k is vector[CHAIN_LEN-1-k]
  assign vsel      = (ph_q == PH_LOAD2) ? v2_q : v1_q;
  assign vsh       = vsel << cnt_q;
  assign scan_in_o = vsh[CHAIN_LEN-1];

  assign shift_o   = (ph_q == PH_LOAD1) || (ph_q == PH_LOAD2) || (ph_q == PH_UNLOAD);
  assign hold_o    = (ph_q == PH_LOAD2) || (ph_q == PH_UNLOAD);
  assign capture_o = (ph_q == PH_RATED) && (cnt_q == R_LAST);
  assign collect_o = (ph_q == PH_UNLOAD);
  assign done_o    = (ph_q == PH_DONE);
  assign pi_o      = pi_q;
endmodule

// File: rtl/tps_unload.sv
module tps_unload #(
  parameter int CHAIN_LEN = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 collect_i,
  input  logic                 bit_i,
  output logic [CHAIN_LEN-1:0] word_o
);
  logic [CHAIN_LEN-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        word_q <= '0;
    else if (collect_i) word_q <= {word_q[CHAIN_LEN-2:0], bit_i};
  end

  assign word_o = word_q;
endmodule

// File: rtl/twopat_scan.sv
module twopat_scan #(
  parameter int CHAIN_LEN  = 8,
  parameter int PI_W       = 4,
  parameter int SETTLE_CYC = 4,
  parameter int RATED_CYC  = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [CHAIN_LEN-1:0] v1_state_i,
  input  logic [CHAIN_LEN-1:0] v2_state_i,
  input  logic [PI_W-1:0]      v1_pi_i,
  input  logic [PI_W-1:0]      v2_pi_i,
  output logic [CHAIN_LEN-1:0] cut_state_o,
  output logic [PI_W-1:0]      cut_pi_o,
  input  logic [CHAIN_LEN-1:0] cut_resp_i,
  output logic                 scan_mode_o,
  output logic                 hold_o,
  output logic                 scan_out_o,
  output logic [CHAIN_LEN-1:0] resp_o,
  output logic                 done_o
);
  logic shift, capture, hold, scan_in, collect, sout;

  tps_seq #(
    .CHAIN_LEN (CHAIN_LEN),
    .PI_W      (PI_W),
    .SETTLE_CYC(SETTLE_CYC),
    .RATED_CYC (RATED_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .v1_state_i (v1_state_i),
    .v2_state_i (v2_state_i),
    .v1_pi_i    (v1_pi_i),
    .v2_pi_i    (v2_pi_i),
    .shift_o    (shift),
    .capture_o  (capture),
    .hold_o     (hold),
    .scan_in_o  (scan_in),
    .collect_o  (collect),
    .pi_o       (cut_pi_o),
    .done_o     (done_o)
  );

  tps_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_i    (shift),
    .capture_i  (capture),
    .hold_i     (hold),
    .scan_in_i  (scan_in),
    .resp_i     (cut_resp_i),
    .state_o    (cut_state_o),
    .scan_out_o (sout)
  );

  tps_unload #(.CHAIN_LEN(CHAIN_LEN)) u_unload (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .collect_i (collect),
    .bit_i     (sout),
    .word_o    (resp_o)
  );

  assign scan_mode_o = !capture;
  assign hold_o      = hold;
  assign scan_out_o  = sout;
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int CHAIN_LEN  = 8,
  parameter int PI_W       = 4,
  parameter int RATED_CYC  = 2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 start_i,
  input logic [CHAIN_LEN-1:0] cut_state_o,
  input logic [PI_W-1:0]      cut_pi_o,
  input logic                 scan_mode_o,
  input logic                 hold_o,
  input logic                 done_o
);
  logic        hold_prev;
  logic [15:0] since_rel;

  // cycles since hold last fell (release)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_prev <= 1'b0;
      since_rel <= '0;
    end else begin
      hold_prev <= hold_o;
      if (hold_prev && !hold_o)  since_rel <= 16'd1;
      else if (since_rel != '1 && since_rel != '0) since_rel <= since_rel + 16'd1;
    end
  end

  AST_HOLD_FREEZES_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> $stable(cut_state_o)); // R3
  AST_HOLD_FREEZES_PI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> $stable(cut_pi_o)); // R3
  AST_CAPTURE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_mode_o |-> !hold_o); // R5
  AST_CAPTURE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_mode_o |=> scan_mode_o); // R6
  AST_CAPTURE_RATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scan_mode_o |-> (since_rel == 16'(RATED_CYC))); // R6
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o); // R8
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (scan_mode_o && !hold_o)); // R8
endmodule

bind twopat_scan tps_checker #(
  .CHAIN_LEN (CHAIN_LEN),
  .PI_W      (PI_W),
  .RATED_CYC (RATED_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cut_state_o (cut_state_o),
  .cut_pi_o    (cut_pi_o),
  .scan_mode_o (scan_mode_o),
  .hold_o      (hold_o),
  .done_o      (done_o)
);

// File: tb/twopat_scan_tb.sv
module twopat_scan_tb;
  localparam int N  = 4;
  localparam int P  = 2;
  localparam int S  = 3;
  localparam int R  = 2;
  localparam int L2_END = 2*N + S;
  localparam int LAUNCH = L2_END + 1;
  localparam int CAP    = LAUNCH + R;
  localparam int FIN    = CAP + N;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [N-1:0] v1 = '0, v2 = '0;
  logic [P-1:0] p1 = '0, p2 = '0;
  logic [N-1:0] cut_state, cut_resp, resp;
  logic [P-1:0] cut_pi;
  logic scan_mode, hold, sout, done;
  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  function automatic logic [N-1:0] logic_fn(logic [N-1:0] s, logic [P-1:0] p);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = s[i] ^ s[(i+1)%N] ^ p[i%P];
    return r;
  endfunction

  assign cut_resp = logic_fn(cut_state, cut_pi);

  twopat_scan #(.CHAIN_LEN(N), .PI_W(P), .SETTLE_CYC(S), .RATED_CYC(R)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .v1_state_i(v1), .v2_state_i(v2), .v1_pi_i(p1), .v2_pi_i(p2),
    .cut_state_o(cut_state), .cut_pi_o(cut_pi), .cut_resp_i(cut_resp),
    .scan_mode_o(scan_mode), .hold_o(hold), .scan_out_o(sout),
    .resp_o(resp), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic run(input logic [N-1:0] a, input logic [N-1:0] b,
                     input logic [P-1:0] pa, input logic [P-1:0] pb, input bit disturb);
    logic [N-1:0] exp_r;
    exp_r = logic_fn(b, pb);
    @(negedge clk);
    v1 = a; v2 = b; p1 = pa; p2 = pb; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= FIN; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (disturb && k == 3) begin
        start = 1'b1; v1 = ~a; v2 = ~b; p1 = ~pa; p2 = ~pb;  // R9 R10 stray start
      end
      if (disturb && k == 4) start = 1'b0;
      if (k == 1) chk(done == 1'b0, "R8", "done cleared by start", done, 0);
      if (k >= N && k < N + S) chk(hold == 1'b0, "R4", "hold low while settling", hold, 0);
      if (k == N + S) begin
        chk(hold == 1'b1, "R4", "hold rises after settle", hold, 1);
        chk(cut_state == a, "R2", "V1 at logic", cut_state, a);
      end
      if (k == L2_END - 1) chk(hold == 1'b1, "R3", "hold during V2 load", hold, 1);
      if (k == L2_END) begin
        chk(cut_state == a, "R3", "V1 frozen after V2 load", cut_state, a);
        chk(cut_pi == pa, "R3", "V1 pi frozen", cut_pi, pa);
        chk(hold == 1'b0, "R5", "hold low on release", hold, 0);
      end
      if (k == LAUNCH) begin
        chk(cut_state == b, "R5", "V2 released", cut_state, b);
        chk(cut_pi == pb, "R5", "V2 pi released", cut_pi, pb);
      end
      if (k >= LAUNCH && k <= CAP)
        chk(scan_mode == (k != CAP - 1), "R6", "capture cycle", scan_mode, (k != CAP - 1));
      if (k >= CAP && k < FIN)
        chk(sout == exp_r[N-1-(k-CAP)], "R7", "serial response bit", sout, exp_r[N-1-(k-CAP)]);
      if (k == FIN - 1) chk(done == 1'b0, "R8", "done not early", done, 0);
      if (k == FIN) begin
        chk(done == 1'b1, "R8", "done after unload", done, 1);
        chk(resp == exp_r, disturb ? "R10" : "R7", "response word", resp, exp_r);
      end
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b1, "R8", "done held", done, 1);
    chk(resp == exp_r, "R9", "result kept", resp, exp_r);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(hold == 1'b0, "R1", "reset hold", hold, 0);
    chk(scan_mode == 1'b1, "R1", "reset scan_mode", scan_mode, 1);
    chk(cut_state == '0, "R1", "reset state", cut_state, 0);
    chk(cut_pi == '0, "R1", "reset pi", cut_pi, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        run(N'(i), N'(j), P'(i + j), P'(3*j + i), bit'(j[0] ^ i[1]));
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule